// File: doc/BRIEF.md
# Multi-channel DMA transfer controller

This block copies words from one address to another without the processor doing the work. The processor sets up each of six logical channels through a small register-write port. For each channel it gives a source address, a destination address, an addressing mode and a word count. Writing the word count starts the channel. Memory and peripheral ports share one word-addressed space. A peripheral is reached by holding its address fixed instead of stepping it.

The engine does not use the shared bus until the processor allows it. It raises a request and starts moving words only while the processor returns a grant. It moves one 32-bit word per cycle: the word is read and written in the same cycle. The processor can take the bus back at any word boundary by raising its own request. The engine then drops its request, and it asks again once the processor lets go. The interrupted channel continues from the next word it had not yet moved.

All six channels share one datapath. In each cycle a fixed-priority arbiter picks one channel. A channel can win only if its source and destination are both ready. When a channel finishes its block, its done flag is set. If that channel's interrupt is enabled, its interrupt line goes high at the same time.

Top module: `dma_engine`

## Requirements
- R1: A write with `cfg_we` high goes to the channel named by `cfg_ch`. The field code selects the target: 0 is the source address, 1 is the destination address and 2 is the mode. Code 3 is the word count; writing it starts the channel and clears that channel's done flag. Code 4 clears the done flag.
- R2: While any channel has words left and `cpu_req` is low, `bus_req` is high from the next cycle. No memory access happens unless `bus_req` and `bus_gnt` are both high.
- R3: In every cycle with a transfer, `mem_ren` and `mem_wen` are both high. The read address is the channel's current source address, the write address is its current destination address, and `mem_wdata` equals `mem_rdata`. At most one word moves per cycle.
- R4: The mode bits decide how addresses move after each word. Bit 0 set holds the source address and bit 1 set holds the destination address. An address whose bit is clear steps up by one after each word.
- R5: In a cycle where `cpu_req` is high, no word moves. `bus_req` is low in the following cycle.
- R6: After the bus has been taken back in the middle of a block, the channel asks for the bus again. It moves the remaining words with no repeats and no gaps.
- R7: Among the channels that are able to move a word, the lowest channel index wins. That channel keeps the datapath until it is done or is no longer eligible.
- R8: A channel whose `src_rdy` or `dst_rdy` bit is low moves no word. Lower-priority channels that are ready move instead.
- R9: The done flag sets in the cycle after a channel's last word moves. `chan_irq` for that channel equals its done flag ANDed with mode bit 2. A clear write lowers both.
- R10: Writing a word count of zero sets the done flag on the next cycle. It causes no bus request and no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 3 | Channel addressed by the write |
| cfg_field | input | 3 | Field code of the write |
| cfg_wdata | input | 32 | Write data |
| src_rdy | input | 6 | Per-channel source ready |
| dst_rdy | input | 6 | Per-channel destination ready |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus grant from the processor |
| cpu_req | input | 1 | Processor asks for the bus back |
| mem_ren | output | 1 | Read strobe |
| mem_raddr | output | 16 | Read word address |
| mem_rdata | input | 32 | Read data, valid in the same cycle |
| mem_wen | output | 1 | Write strobe |
| mem_waddr | output | 16 | Write word address |
| mem_wdata | output | 32 | Write data |
| chan_done | output | 6 | Per-channel block-complete flags |
| chan_irq | output | 6 | Per-channel interrupt lines |

## Verification
The assertions check the following on every cycle:
- no memory access without both request and grant;
- read and write are paired and carry the same word;
- the request falls one cycle after `cpu_req`;
- the winning channel is unique, eligible and lowest-indexed;
- each per-channel address steps or holds according to its mode;
- a zero count leads directly to done.

The bench's scenarios check the results over whole blocks:
- the copied memory contents;
- the order in which competing channels are served;
- a block that is interrupted and then resumed with no repeated or missing word;
- interrupt gating and done clearing as seen at the ports.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int NCH = 6;
    localparam int AW  = 16;
    localparam int DW  = 32;
    localparam int CW  = 16;
    localparam int CHW = $clog2(NCH);
    localparam int FW  = 3;

    typedef enum logic [FW-1:0] {
        FLD_SRC   = 3'd0,
        FLD_DST   = 3'd1,
        FLD_MODE  = 3'd2,
        FLD_COUNT = 3'd3,
        FLD_CLEAR = 3'd4
    } fld_e;

    typedef struct packed {
        logic irq_en;
        logic dst_hold;
        logic src_hold;
    } mode_t;

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] left;
        mode_t         mode;
        logic          done;
    } chan_t;

    function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a, input logic hold);
        return hold ? a : a + 1'b1;
    endfunction
endpackage

// File: rtl/dma_channel.sv
module dma_channel
    import dma_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_hit,
    input  fld_e          wr_fld,
    input  logic [DW-1:0] wr_data,
    input  logic          step,
    output chan_t         st,
    output logic          pending
);
    logic [CW-1:0] wr_count;
    assign wr_count = wr_data[CW-1:0];
    assign pending  = (st.left != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (wr_hit) begin
            case (wr_fld)
                FLD_SRC:   st.src  <= wr_data[AW-1:0];
                FLD_DST:   st.dst  <= wr_data[AW-1:0];
                FLD_MODE:  st.mode <= mode_t'(wr_data[2:0]);
                FLD_COUNT: begin
                    st.left <= wr_count;
                    st.done <= (wr_count == '0);
                end
                FLD_CLEAR: st.done <= 1'b0;
                default:   ;
            endcase
        end else if (step) begin
            st.src  <= next_addr(st.src, st.mode.src_hold);
            st.dst  <= next_addr(st.dst, st.mode.dst_hold);
            st.left <= st.left - 1'b1;
            if (st.left == CW'(1)) st.done <= 1'b1;
        end
    end

    a_r10_zero_done: assert property (@(posedge clk) disable iff (rst)
        wr_hit && wr_fld == FLD_COUNT && wr_count == '0 |=> st.done && !pending);
    a_r9_done_after_last: assert property (@(posedge clk) disable iff (rst)
        step && !wr_hit && st.left == CW'(1) |=> st.done && !pending);
    a_r3_step_has_work: assert property (@(posedge clk) disable iff (rst)
        step |-> pending);
    a_r4_src_advance: assert property (@(posedge clk) disable iff (rst)
        step && !wr_hit && !st.mode.src_hold |=> st.src == AW'($past(st.src) + 1'b1));
    a_r4_src_held: assert property (@(posedge clk) disable iff (rst)
        step && !wr_hit && st.mode.src_hold |=> $stable(st.src));
    a_r4_dst_held: assert property (@(posedge clk) disable iff (rst)
        step && !wr_hit && st.mode.dst_hold |=> $stable(st.dst));
endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter
    import dma_pkg::*;
#(
    parameter int N  = NCH,
    parameter int IW = CHW
) (
    input  logic [N-1:0]  elig,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        gnt = '0;
        idx = '0;
        any = |elig;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dma_busctl.sv
module dma_busctl (
    input  logic clk,
    input  logic rst,
    input  logic any_pending,
    input  logic any_elig,
    input  logic cpu_req,
    input  logic bus_gnt,
    output logic bus_req,
    output logic move
);
    always_ff @(posedge clk) begin
        if (rst) bus_req <= 1'b0;
        else     bus_req <= any_pending && !cpu_req;
    end

    assign move = bus_req && bus_gnt && !cpu_req && any_elig;

    a_r5_release: assert property (@(posedge clk) disable iff (rst)
        cpu_req |=> !bus_req);
    a_r5_no_move_on_cpu_req: assert property (@(posedge clk) disable iff (rst)
        cpu_req |-> !move);
    a_r2_request_follows_work: assert property (@(posedge clk) disable iff (rst)
        any_pending && !cpu_req |=> bus_req);
endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [CHW-1:0]  cfg_ch,
    input  logic [FW-1:0]   cfg_field,
    input  logic [DW-1:0]   cfg_wdata,
    input  logic [NCH-1:0]  src_rdy,
    input  logic [NCH-1:0]  dst_rdy,
    output logic            bus_req,
    input  logic            bus_gnt,
    input  logic            cpu_req,
    output logic            mem_ren,
    output logic [AW-1:0]   mem_raddr,
    input  logic [DW-1:0]   mem_rdata,
    output logic            mem_wen,
    output logic [AW-1:0]   mem_waddr,
    output logic [DW-1:0]   mem_wdata,
    output logic [NCH-1:0]  chan_done,
    output logic [NCH-1:0]  chan_irq
);
    chan_t          st      [NCH];
    logic [NCH-1:0] pending;
    logic [NCH-1:0] elig;
    logic [NCH-1:0] gnt;
    logic [NCH-1:0] step;
    logic [CHW-1:0] win;
    logic           any_elig;
    logic           move;
    fld_e           fld;

    assign fld  = fld_e'(cfg_field);
    assign elig = pending & src_rdy & dst_rdy;
    assign step = gnt & {NCH{move}};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dma_channel u_ch (
            .clk     (clk),
            .rst     (rst),
            .wr_hit  (cfg_we && cfg_ch == CHW'(c)),
            .wr_fld  (fld),
            .wr_data (cfg_wdata),
            .step    (step[c]),
            .st      (st[c]),
            .pending (pending[c])
        );
        assign chan_done[c] = st[c].done;
        assign chan_irq[c]  = st[c].done && st[c].mode.irq_en;
    end

    dma_arbiter #(.N(NCH), .IW(CHW)) u_arb (
        .elig (elig),
        .gnt  (gnt),
        .idx  (win),
        .any  (any_elig)
    );

    dma_busctl u_bus (
        .clk         (clk),
        .rst         (rst),
        .any_pending (|pending),
        .any_elig    (any_elig),
        .cpu_req     (cpu_req),
        .bus_gnt     (bus_gnt),
        .bus_req     (bus_req),
        .move        (move)
    );

    assign mem_ren   = move;
    assign mem_wen   = move;
    assign mem_raddr = st[win].src;
    assign mem_waddr = st[win].dst;
    assign mem_wdata = mem_rdata;

    a_r2_access_needs_grant: assert property (@(posedge clk) disable iff (rst)
        (mem_ren || mem_wen) |-> bus_req && bus_gnt);
    a_r3_paired_copy: assert property (@(posedge clk) disable iff (rst)
        mem_wen |-> mem_ren && mem_wdata == mem_rdata);
    a_r7_single_lowest_winner: assert property (@(posedge clk) disable iff (rst)
        any_elig |-> $onehot(gnt) && (elig & (gnt - 1'b1)) == '0 && (gnt & ~elig) == '0);
    a_r8_winner_ready: assert property (@(posedge clk) disable iff (rst)
        mem_wen |-> src_rdy[win] && dst_rdy[win]);
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
        (chan_irq & ~chan_done) == '0);
endmodule

// File: tb/tb_dma_engine.sv
module tb_dma_engine;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_ch = '0;
    logic [2:0]  cfg_field = '0;
    logic [31:0] cfg_wdata = '0;
    logic [5:0]  src_rdy = '1;
    logic [5:0]  dst_rdy = '1;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic        cpu_req = 1'b0;
    logic        mem_ren, mem_wen;
    logic [15:0] mem_raddr, mem_waddr;
    logic [31:0] mem_rdata, mem_wdata;
    logic [5:0]  chan_done, chan_irq;

    logic        allow_gnt = 1'b1;
    logic        req_seen = 1'b0;
    logic [31:0] mem [256];
    logic [15:0] wlog [1024];
    int          wcnt = 0;
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;

    dma_engine dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_field(cfg_field),
        .cfg_wdata(cfg_wdata), .src_rdy(src_rdy), .dst_rdy(dst_rdy), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .cpu_req(cpu_req), .mem_ren(mem_ren), .mem_raddr(mem_raddr),
        .mem_rdata(mem_rdata), .mem_wen(mem_wen), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .chan_done(chan_done), .chan_irq(chan_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] initv(input int a);
        return 32'h1234_5678 + a * 32'h9E37;
    endfunction

    assign mem_rdata = mem[mem_raddr[7:0]];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= initv(i);
        end else if (mem_wen) begin
            mem[mem_waddr[7:0]] <= mem_wdata;
            wlog[wcnt] <= mem_waddr;
            wcnt <= wcnt + 1;
        end
        bus_gnt <= bus_req && allow_gnt && !cpu_req;
        if (bus_req) req_seen <= 1'b1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            errors++;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg(input int ch, input int fld, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_field = 3'(fld); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input int ch, input int src, input int dst, input int mode, input int n);
        cfg(ch, 0, 32'(src));
        cfg(ch, 1, 32'(dst));
        cfg(ch, 2, 32'(mode));
        cfg(ch, 3, 32'(n));
    endtask

    task automatic wait_done(input int ch);
        for (int i = 0; i < 200 && !chan_done[ch]; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        check(bus_req == 0, "R2 reset bus_req", bus_req, 0);
        check(chan_done == 0, "R9 reset done", chan_done, 0);
        check(chan_irq == 0, "R9 reset irq", chan_irq, 0);
        check(mem_wen == 0, "R3 reset mem_wen", mem_wen, 0);
    endtask

    task automatic t_basic;
        int base = wcnt;
        setup(0, 'h10, 'h40, 0, 4);
        @(negedge clk);
        check(bus_req == 1, "R1 R2 count write raises request", bus_req, 1);
        wait_done(0);
        check(chan_done[0] == 1, "R9 block done", chan_done[0], 1);
        check(wcnt - base == 4, "R3 word count", wcnt - base, 4);
        for (int k = 0; k < 4; k++)
            check(mem['h40 + k] == initv('h10 + k), "R3 R4 copied data", mem['h40 + k], initv('h10 + k));
        check(chan_irq[0] == 0, "R9 irq disabled", chan_irq[0], 0);
        @(negedge clk);
        check(bus_req == 0, "R2 request drops when idle", bus_req, 0);
    endtask

    task automatic t_zero;
        int base = wcnt;
        @(negedge clk);
        req_seen = 1'b0;
        cfg(1, 3, 0);
        check(chan_done[1] == 1, "R10 zero count done", chan_done[1], 1);
        repeat (3) @(negedge clk);
        check(req_seen == 0, "R10 no bus request", req_seen, 0);
        check(wcnt == base, "R10 no transfer", wcnt - base, 0);
    endtask

    task automatic t_irq;
        setup(2, 'h44, 'hD0, 4, 2);
        wait_done(2);
        check(chan_irq[2] == 1, "R9 irq raised", chan_irq[2], 1);
        check(mem['hD1] == initv('h45), "R3 irq block data", mem['hD1], initv('h45));
        cfg(2, 4, 0);
        check(chan_done[2] == 0, "R9 done cleared", chan_done[2], 0);
        check(chan_irq[2] == 0, "R9 irq cleared", chan_irq[2], 0);
    endtask

    task automatic t_hold;
        setup(3, 'hF0, 'hE0, 1, 3);
        wait_done(3);
        for (int k = 0; k < 3; k++)
            check(mem['hE0 + k] == initv('hF0), "R4 fixed source", mem['hE0 + k], initv('hF0));
        setup(3, 'h48, 'hEC, 2, 3);
        wait_done(3);
        check(mem['hEC] == initv('h4A), "R4 fixed destination last word", mem['hEC], initv('h4A));
        check(mem['hED] == initv('hED), "R4 fixed destination no spill", mem['hED], initv('hED));
    endtask

    task automatic t_priority;
        int base;
        allow_gnt = 1'b0;
        setup(4, 'h30, 'h70, 0, 2);
        setup(1, 'h34, 'h60, 0, 2);
        base = wcnt;
        allow_gnt = 1'b1;
        wait_done(4);
        wait_done(1);
        check(wlog[base] == 'h60, "R7 first winner ch1", wlog[base], 'h60);
        check(wlog[base+1] == 'h61, "R7 ch1 keeps datapath", wlog[base+1], 'h61);
        check(wlog[base+2] == 'h70, "R7 ch4 after ch1", wlog[base+2], 'h70);
        check(wlog[base+3] == 'h71, "R7 ch4 second", wlog[base+3], 'h71);
    endtask

    task automatic t_ready;
        int base;
        allow_gnt = 1'b0;
        src_rdy[0] = 1'b0;
        setup(0, 'h38, 'hB0, 0, 2);
        setup(5, 'h3C, 'hC0, 0, 2);
        base = wcnt;
        allow_gnt = 1'b1;
        wait_done(5);
        repeat (3) @(negedge clk);
        check(chan_done[0] == 0, "R8 unready channel waits", chan_done[0], 0);
        check(wcnt - base == 2, "R8 only ready channel moved", wcnt - base, 2);
        check(wlog[base] == 'hC0, "R8 lower priority served", wlog[base], 'hC0);
        src_rdy[0] = 1'b1;
        wait_done(0);
        check(mem['hB1] == initv('h39), "R8 channel resumes when ready", mem['hB1], initv('h39));
    endtask

    task automatic t_preempt;
        int base, held;
        setup(0, 'h20, 'hA0, 0, 6);
        base = wcnt;
        for (int i = 0; i < 100 && wcnt - base < 2; i++) @(negedge clk);
        cpu_req = 1'b1;
        @(negedge clk);
        check(bus_req == 0, "R5 request released", bus_req, 0);
        held = wcnt;
        check(held - base == 2, "R5 no word during cpu request", held - base, 2);
        repeat (5) @(negedge clk);
        check(wcnt == held, "R5 bus stays released", wcnt - base, 2);
        check(chan_done[0] == 0, "R6 block not complete", chan_done[0], 0);
        cpu_req = 1'b0;
        wait_done(0);
        check(wcnt - base == 6, "R6 total words", wcnt - base, 6);
        for (int k = 0; k < 6; k++) begin
            check(wlog[base+k] == 16'('hA0 + k), "R6 resume order", wlog[base+k], 'hA0 + k);
            check(mem['hA0 + k] == initv('h20 + k), "R6 resume data", mem['hA0 + k], initv('h20 + k));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_zero();
        t_irq();
        t_hold();
        t_priority();
        t_ready();
        t_preempt();
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule